// File: doc/BRIEF.md
# Prescaled General-Purpose Timer with Compare and Capture

This block is a bus-attached timer. It has a prescaled up-counter, three output-compare channels that drive pins and two input-capture channels that latch the count on edges of external inputs. Software reaches it through a simple word-wide register port. The port has an address, a write strobe, a read strobe and data in both directions. Reads are combinational.

The counter is clocked by a tick that is chosen from three clock-enable inputs. Ticks are divided by a programmable prescaler, and each enabled source tick advances the prescaler. The counter either runs freely and wraps, or returns to zero after it matches the first compare register. A wait input freezes counting unless software allows counting in wait mode. Every event sets a status flag. Writing 1 to a flag clears it, and an enabled flag raises the single interrupt output.

Top module: `gp_timer`

## Requirements
- R1: Word registers are decoded from addr_i[5:2] and need addr_i[1:0]=0: control 0x00, prescaler 0x04, status 0x08, interrupt enable 0x0C, compare 1/2/3 at 0x10/0x14/0x18, capture 1/2 at 0x1C/0x20, counter 0x24. Written registers read back their value. Writes to the counter and capture registers are ignored. After reset the compare registers hold all ones and every other register holds zero. rdata_o is 0 while rd_i is low.
- R2: Writing control bit 15 sets a soft reset. Control reads back with bit 15 set for one cycle. On the following edge every register, the counter and the pins return to their reset values.
- R3: Control[8:6] selects the tick source: 1 = src_en_i[0], 2 = src_en_i[1], 4 = src_en_i[2], and any other code halts counting. The counter advances once for every (prescaler+1) selected ticks.
- R4: The counter runs only while control bit 0 is set. While wait_i is high and control bit 3 is clear, the counter and the prescaler hold their values.
- R5: With control bit 9 set, the counter runs free. It wraps from all ones to 0 and sets status bit 5.
- R6: With control bit 9 clear, a count tick taken while the counter equals compare 1 returns the counter to 0.
- R7: A compare channel matches when a count tick brings the counter to its compare value, and the match sets status bit 0, 1 or 2 for channel 1, 2 or 3. The pin mode fields are control[22:20], [25:23] and [28:26] for channels 1, 2 and 3. The modes are: 0 = pin held low, 1 = toggle, 2 = drive low, 3 = drive high, 4 to 7 = pin high for exactly the one cycle after the event.
- R8: Writing 1 to control bit 29, 30 or 31 applies the pin action of channel 1, 2 or 3 at once. These bits do not set a status flag and read back as 0.
- R9: The capture edge fields are control[17:16] for channel 1 and [19:18] for channel 2: 0 = off, 1 = rising, 2 = falling, 3 = both. On the chosen edge of cap_i, the counter value before that edge's update is latched, and status bit 3 or 4 is set.
- R10: Writing 1 to a status bit clears it, but an event in the same cycle wins. irq_o is high when any status bit is set and its enable bit is set.
- R11: When control bit 1 is set, a write that turns control bit 0 from 0 to 1 clears the counter and the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the register |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| src_en_i | input | 3 | Clock-enable inputs that the tick source is chosen from |
| wait_i | input | 1 | Wait-mode indication |
| cap_i | input | 2 | Capture inputs |
| cmp_o | output | 3 | Compare output pins |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench goes after the edges of the count: the wrap from all ones, the return to zero in restart mode, and a compare value that is reached only after the restart. A design with an off-by-one in restart or prescale would drift by a tick and show a wrong counter or pin one cycle early or late. It also checks that the pulse mode drops after one cycle, that a forced action sets no flag, and that a capture latches the count from before the edge rather than after it. Further targets are a status clear that arrives in the same cycle as a new event, wait-mode gating, and the bit-15 readback in the cycle before the soft reset lands. A design that cleared before setting, or reset at once, would report these as mismatches.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NUM_CMP = 3;
  localparam int unsigned NUM_CAP = 2;
  localparam int unsigned ST_W    = NUM_CMP + NUM_CAP + 1;

  typedef enum logic [3:0] {
    RA_CTRL  = 4'd0,
    RA_PRESC = 4'd1,
    RA_STAT  = 4'd2,
    RA_IEN   = 4'd3,
    RA_CMP0  = 4'd4,
    RA_CMP1  = 4'd5,
    RA_CMP2  = 4'd6,
    RA_CAP0  = 4'd7,
    RA_CAP1  = 4'd8,
    RA_CNT   = 4'd9
  } reg_idx_e;

  typedef enum logic [2:0] {
    PIN_OFF  = 3'd0,
    PIN_TOG  = 3'd1,
    PIN_LOW  = 3'd2,
    PIN_HIGH = 3'd3
  } pin_mode_e;

  localparam logic [2:0] SRC_PCLK = 3'd1;
  localparam logic [2:0] SRC_FAST = 3'd2;
  localparam logic [2:0] SRC_SLOW = 3'd4;

  localparam int unsigned CTL_EN      = 0;
  localparam int unsigned CTL_ENMODE  = 1;
  localparam int unsigned CTL_WAITRUN = 3;
  localparam int unsigned CTL_SRC_LO  = 6;
  localparam int unsigned CTL_FREERUN = 9;
  localparam int unsigned CTL_SRST    = 15;
  localparam int unsigned CTL_CAP_LO  = 16;
  localparam int unsigned CTL_CMP_LO  = 20;
  localparam int unsigned CTL_FRC_LO  = 29;
endpackage

// File: rtl/tmr_tick.sv
module tmr_tick import tmr_pkg::*; #(
  parameter int unsigned PRE_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             clr_i,
  input  logic [2:0]       src_en_i,
  input  logic [2:0]       src_sel_i,
  input  logic             en_i,
  input  logic             wait_i,
  input  logic             wait_run_i,
  input  logic [PRE_W-1:0] presc_i,
  output logic             tick_o
);
  logic             src_hit;
  logic             step;
  logic [PRE_W-1:0] div_q;

  always_comb begin
    case (src_sel_i)
      SRC_PCLK: src_hit = src_en_i[0];
      SRC_FAST: src_hit = src_en_i[1];
      SRC_SLOW: src_hit = src_en_i[2];
      default:  src_hit = 1'b0;
    endcase
  end

  assign step   = src_hit & en_i & (~wait_i | wait_run_i);
  assign tick_o = step && (div_q == presc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             div_q <= '0;
    else if (srst_i || clr_i) div_q <= '0;
    else if (step)           div_q <= tick_o ? '0 : div_q + 1'b1;
  end
endmodule

// File: rtl/tmr_oc.sv
module tmr_oc import tmr_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       srst_i,
  input  logic [2:0] mode_i,
  input  logic       hit_i,
  input  logic       force_i,
  output logic       pin_o
);
  logic act;
  assign act = hit_i | force_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pin_o <= 1'b0;
    else if (srst_i) pin_o <= 1'b0;
    else begin
      case (mode_i)
        PIN_OFF:  pin_o <= 1'b0;
        PIN_TOG:  if (act) pin_o <= ~pin_o;
        PIN_LOW:  if (act) pin_o <= 1'b0;
        PIN_HIGH: if (act) pin_o <= 1'b1;
        default:  pin_o <= act;  // one-cycle pulse
      endcase
    end
  end
endmodule

// File: rtl/tmr_ic.sv
module tmr_ic #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] val_o,
  output logic             evt_o
);
  logic cap_q;
  logic rise, fall;

  assign rise  = cap_i & ~cap_q;
  assign fall  = ~cap_i & cap_q;
  assign evt_o = (edge_sel_i[0] & rise) | (edge_sel_i[1] & fall);

  // edge history survives soft reset so a held level is not seen as an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_q <= 1'b0;
    else         cap_q <= cap_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_o <= '0;
    else if (srst_i) val_o <= '0;
    else if (evt_o)  val_o <= cnt_i;
  end
endmodule

// File: rtl/gp_timer.sv
module gp_timer import tmr_pkg::*; #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PRE_W  = 12,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [2:0]        src_en_i,
  input  logic              wait_i,
  input  logic [NUM_CAP-1:0] cap_i,
  output logic [NUM_CMP-1:0] cmp_o,
  output logic              irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [3:0]       idx;
  logic             acc_ok, wr_en, wr_ctrl, wr_stat;
  logic [31:0]      ctrl_q;
  logic [PRE_W-1:0] presc_q;
  logic [ST_W-1:0]  sts_q, ien_q, sts_set, sts_clr;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [CNT_W-1:0] cmp_q   [NUM_CMP];
  logic [CNT_W-1:0] cap_val [NUM_CAP];
  logic [NUM_CMP-1:0] hit, frc;
  logic [NUM_CAP-1:0] cap_evt;
  logic             srst, tick, restart_hit, rov, en_clr;
  logic [31:0]      rd_mux;

  assign idx     = addr_i[5:2];
  assign acc_ok  = (addr_i[1:0] == 2'b00);
  assign wr_en   = wr_i & acc_ok;
  assign wr_ctrl = wr_en && (idx == RA_CTRL);
  assign wr_stat = wr_en && (idx == RA_STAT);
  assign srst    = ctrl_q[CTL_SRST];
  assign en_clr  = wr_ctrl && !ctrl_q[CTL_EN] && wdata_i[CTL_EN] && wdata_i[CTL_ENMODE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (srst)    ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= {3'b000, wdata_i[28:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      ien_q   <= '0;
    end else if (srst) begin
      presc_q <= '0;
      ien_q   <= '0;
    end else if (wr_en) begin
      if (idx == RA_PRESC) presc_q <= wdata_i[PRE_W-1:0];
      if (idx == RA_IEN)   ien_q   <= wdata_i[ST_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_CMP; i++) cmp_q[i] <= CNT_MAX;
    end else if (srst) begin
      for (int i = 0; i < NUM_CMP; i++) cmp_q[i] <= CNT_MAX;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_CMP; i++)
        if (idx == 4'(RA_CMP0) + 4'(i)) cmp_q[i] <= wdata_i[CNT_W-1:0];
    end
  end

  tmr_tick #(.PRE_W(PRE_W)) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .srst_i     (srst),
    .clr_i      (en_clr),
    .src_en_i   (src_en_i),
    .src_sel_i  (ctrl_q[CTL_SRC_LO +: 3]),
    .en_i       (ctrl_q[CTL_EN]),
    .wait_i     (wait_i),
    .wait_run_i (ctrl_q[CTL_WAITRUN]),
    .presc_i    (presc_q),
    .tick_o     (tick)
  );

  assign restart_hit = !ctrl_q[CTL_FREERUN] && (cnt_q == cmp_q[0]);
  assign cnt_nxt     = restart_hit ? '0 : cnt_q + 1'b1;
  assign rov         = tick && (cnt_q == CNT_MAX) && !restart_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (srst)   cnt_q <= '0;
    else if (en_clr) cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_nxt;
  end

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    assign hit[i] = tick && (cnt_nxt == cmp_q[i]);
    assign frc[i] = wr_ctrl && wdata_i[CTL_FRC_LO+i];
    tmr_oc u_oc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .srst_i  (srst),
      .mode_i  (ctrl_q[CTL_CMP_LO+3*i +: 3]),
      .hit_i   (hit[i]),
      .force_i (frc[i]),
      .pin_o   (cmp_o[i])
    );
  end

  for (genvar i = 0; i < NUM_CAP; i++) begin : g_cap
    tmr_ic #(.CNT_W(CNT_W)) u_ic (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .srst_i     (srst),
      .edge_sel_i (ctrl_q[CTL_CAP_LO+2*i +: 2]),
      .cap_i      (cap_i[i]),
      .cnt_i      (cnt_q),
      .val_o      (cap_val[i]),
      .evt_o      (cap_evt[i])
    );
  end

  assign sts_set = {rov, cap_evt, hit};
  assign sts_clr = wr_stat ? wdata_i[ST_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sts_q <= '0;
    else if (srst) sts_q <= '0;
    else           sts_q <= (sts_q & ~sts_clr) | sts_set;
  end

  assign irq_o = |(sts_q & ien_q);

  always_comb begin
    case (idx)
      RA_CTRL:  rd_mux = ctrl_q;
      RA_PRESC: rd_mux = 32'(presc_q);
      RA_STAT:  rd_mux = 32'(sts_q);
      RA_IEN:   rd_mux = 32'(ien_q);
      RA_CMP0:  rd_mux = 32'(cmp_q[0]);
      RA_CMP1:  rd_mux = 32'(cmp_q[1]);
      RA_CMP2:  rd_mux = 32'(cmp_q[2]);
      RA_CAP0:  rd_mux = 32'(cap_val[0]);
      RA_CAP1:  rd_mux = 32'(cap_val[1]);
      RA_CNT:   rd_mux = 32'(cnt_q);
      default:  rd_mux = '0;
    endcase
    rdata_o = (rd_i && acc_ok) ? rd_mux : '0;
  end
endmodule

// File: rtl/gp_timer_chk.sv
module gp_timer_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wait_i,
  input logic             wr_ctrl,
  input logic [31:0]      ctrl_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] cmp1_q,
  input logic [5:0]       sts_q,
  input logic             tick,
  input logic [2:0]       hit,
  input logic [2:0]       frc,
  input logic [1:0]       cap_evt,
  input logic [2:0]       cmp_o
);
  assert_srst_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[15] |=> (ctrl_q == '0 && cnt_q == '0 && sts_q == '0));

  assert_count_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1) || cnt_q == '0));

  assert_wait_freeze_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_i && !ctrl_q[3] && !wr_ctrl && !ctrl_q[15]) |=> $stable(cnt_q));

  assert_rollover_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_q) == {CNT_W{1'b1}} && cnt_q == '0 && $past(ctrl_q[9]) &&
     !$past(ctrl_q[15]) && !$past(wr_ctrl)) |-> sts_q[5]);

  assert_restart_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !ctrl_q[9] && cnt_q == cmp1_q && !ctrl_q[15] && !wr_ctrl) |=> (cnt_q == '0));

  assert_pulse_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[22:20] >= 3'd4 && !hit[0] && !frc[0] && !wr_ctrl) |=> !cmp_o[0]);

  assert_capture_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt[0] && !ctrl_q[15]) |=> sts_q[3]);
endmodule

bind gp_timer gp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wait_i  (wait_i),
  .wr_ctrl (wr_ctrl),
  .ctrl_q  (ctrl_q),
  .cnt_q   (cnt_q),
  .cmp1_q  (cmp_q[0]),
  .sts_q   (sts_q),
  .tick    (tick),
  .hit     (hit),
  .frc     (frc),
  .cap_evt (cap_evt),
  .cmp_o   (cmp_o)
);

// File: tb/gp_timer_test.sv
module gp_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 10;
  localparam logic [TW-1:0] MASK = {TW{1'b1}};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  addr_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [2:0]  src_en_i = '0;
  logic        wait_i = 1'b0;
  logic [1:0]  cap_i = '0;
  logic [2:0]  cmp_o;
  logic        irq_o;

  gp_timer #(.CNT_W(TW), .PRE_W(12), .ADDR_W(6)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .src_en_i(src_en_i), .wait_i(wait_i),
    .cap_i(cap_i), .cmp_o(cmp_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_err = 0;
  bit run_chk = 0, done = 0;

  // reference model state
  logic [31:0]   m_ctrl;
  logic [11:0]   m_presc, m_pc;
  logic [5:0]    m_sts, m_ier;
  logic [TW-1:0] m_cmp [3];
  logic [TW-1:0] m_cap [2];
  logic [TW-1:0] m_cnt;
  logic [2:0]    m_pin;
  logic [1:0]    m_capq;

  task automatic m_soft();
    m_ctrl = 0; m_presc = 0; m_pc = 0; m_sts = 0; m_ier = 0;
    for (int i = 0; i < 3; i++) m_cmp[i] = MASK;
    for (int j = 0; j < 2; j++) m_cap[j] = 0;
    m_cnt = 0; m_pin = 0;
  endtask

  task automatic m_step();
    int a; bit wr_ok, wc, s, go, tk, restart, h, act, r, f, e;
    logic [TW-1:0] nx; logic [5:0] set, clr; int md, em;
    wr_ok = wr_i && (addr_i[1:0] == 0);
    a = int'(addr_i[5:2]);
    wc = wr_ok && a == 0;
    case (m_ctrl[8:6]) 3'd1: s = src_en_i[0]; 3'd2: s = src_en_i[1]; 3'd4: s = src_en_i[2]; default: s = 0; endcase
    go = s && m_ctrl[0] && (!wait_i || m_ctrl[3]);
    tk = go && (m_pc == m_presc);
    if (go) m_pc = tk ? 12'd0 : m_pc + 12'd1;
    restart = !m_ctrl[9] && (m_cnt == m_cmp[0]);
    nx = restart ? '0 : m_cnt + 1'b1;
    set = 0;
    if (tk && m_cnt == MASK && !restart) set[5] = 1;
    for (int i = 0; i < 3; i++) begin
      h = tk && (nx == m_cmp[i]);
      if (h) set[i] = 1;
      act = h || (wc && wdata_i[29+i]);
      md = int'((m_ctrl >> (20 + 3*i)) & 32'h7);
      if (md == 0) m_pin[i] = 0;
      else if (md == 1) begin if (act) m_pin[i] = ~m_pin[i]; end
      else if (md == 2) begin if (act) m_pin[i] = 0; end
      else if (md == 3) begin if (act) m_pin[i] = 1; end
      else m_pin[i] = act;
    end
    for (int j = 0; j < 2; j++) begin
      em = int'((m_ctrl >> (16 + 2*j)) & 32'h3);
      r = cap_i[j] && !m_capq[j];
      f = !cap_i[j] && m_capq[j];
      e = (em == 1 && r) || (em == 2 && f) || (em == 3 && (r || f));
      if (e) begin set[3+j] = 1; m_cap[j] = m_cnt; end
    end
    if (tk) m_cnt = nx;
    clr = (wr_ok && a == 2) ? wdata_i[5:0] : 6'd0;
    m_sts = (m_sts & ~clr) | set;
    if (wr_ok) begin
      case (a)
        0: begin
          if (!m_ctrl[0] && wdata_i[0] && wdata_i[1]) begin m_cnt = 0; m_pc = 0; end
          m_ctrl = {3'b000, wdata_i[28:0]};
        end
        1: m_presc = wdata_i[11:0];
        3: m_ier = wdata_i[5:0];
        4, 5, 6: m_cmp[a-4] = wdata_i[TW-1:0];
        default: ;
      endcase
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin m_soft(); m_capq = 0; end
    else begin
      if (m_ctrl[15]) m_soft();
      else m_step();
      m_capq = cap_i;
    end
  end

  function automatic logic [31:0] m_read(logic [5:0] ad);
    case (ad[5:2])
      4'd0: return m_ctrl;
      4'd1: return {20'd0, m_presc};
      4'd2: return {26'd0, m_sts};
      4'd3: return {26'd0, m_ier};
      4'd4: return 32'(m_cmp[0]);
      4'd5: return 32'(m_cmp[1]);
      4'd6: return 32'(m_cmp[2]);
      4'd7: return 32'(m_cap[0]);
      4'd8: return 32'(m_cap[1]);
      4'd9: return 32'(m_cnt);
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // per-cycle comparison of registered outputs
  always @(negedge clk_i) begin
    if (rst_ni && run_chk) begin
      chk("R7 cmp pins", 32'(cmp_o), 32'(m_pin));
      chk("R10 irq", 32'(irq_o), 32'(|(m_sts & m_ier)));
    end
  end

  // tick sources
  int cyc = 0;
  logic [7:0] lf = 8'h5A;
  always @(negedge clk_i) begin
    cyc++;
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    src_en_i = {(cyc % 5 == 0), lf[0], 1'b1};
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(logic [5:0] ad, logic [31:0] d);
    addr_i = ad; wdata_i = d; wr_i = 1;
    @(negedge clk_i);
    wr_i = 0; wdata_i = 0;
  endtask

  task automatic rd_chk(logic [5:0] ad, string tag);
    addr_i = ad; rd_i = 1;
    #1;
    chk(tag, rdata_o, m_read(ad));
    rd_i = 0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  localparam logic [31:0] EN = 32'h1, ENM = 32'h2, WRUN = 32'h8, FR = 32'h200;
  localparam logic [31:0] S1 = 32'h40, S2 = 32'h80, S4 = 32'h100, S3 = 32'hC0;

  initial begin
    idle(3);
    rst_ni = 1;
    idle(1);
    run_chk = 1;
    // R1 reset values
    for (int k = 0; k < 11; k++) rd_chk(6'(k*4), "R1 reset read");
    chk("R1 cmp1 reset all ones", 32'(m_cmp[0]), 32'(MASK));
    addr_i = 6'h24; rd_i = 0; #1; chk("R1 rdata low without rd", rdata_o, 32'd0);
    // R1 readback and ignored writes
    wr(6'h04, 32'd2); wr(6'h0C, 32'h3F); wr(6'h10, 32'd5); wr(6'h14, 32'd9); wr(6'h18, 32'd13);
    wr(6'h24, 32'h55); wr(6'h1C, 32'h77); wr(6'h11, 32'h3);
    for (int k = 0; k < 10; k++) rd_chk(6'(k*4), "R1 readback");
    wr(6'h0C, 32'h0);
    // R3 sources and prescale
    wr(6'h00, EN | FR | S1); idle(30); rd_chk(6'h24, "R3 src1 count");
    wr(6'h00, EN | FR | S2); idle(40); rd_chk(6'h24, "R3 src2 count");
    wr(6'h00, EN | FR | S4); idle(50); rd_chk(6'h24, "R3 src4 count");
    wr(6'h00, EN | FR | S3); idle(20); rd_chk(6'h24, "R3 invalid source halts");
    // R4 enable and wait
    wr(6'h00, FR | S1); idle(10); rd_chk(6'h24, "R4 disabled holds");
    wr(6'h00, EN | FR | S1); wait_i = 1; idle(12); rd_chk(6'h24, "R4 wait freezes");
    wr(6'h00, EN | WRUN | FR | S1); idle(12); rd_chk(6'h24, "R4 wait run");
    wait_i = 0;
    // R11 enable-mode clear, then compare modes (R7)
    wr(6'h04, 32'd0);
    wr(6'h00, FR | S1);
    wr(6'h00, EN | ENM | FR | S1 | (32'd1 << 20) | (32'd3 << 23) | (32'd4 << 26));
    rd_chk(6'h24, "R11 clear on enable");
    idle(20); rd_chk(6'h08, "R7 compare flags");
    chk("R7 pin after toggle", 32'(cmp_o), 32'(m_pin));
    wr(6'h08, 32'h3F); rd_chk(6'h08, "R10 w1c clears");
    // R6 restart mode
    wr(6'h00, S1);
    wr(6'h10, 32'd6); wr(6'h14, 32'd0); wr(6'h18, 32'd3);
    wr(6'h00, EN | ENM | S1 | (32'd2 << 20) | (32'd1 << 23) | (32'd7 << 26));
    idle(5); rd_chk(6'h24, "R6 restart count");
    idle(7); rd_chk(6'h24, "R6 restart wrapped");
    idle(9); rd_chk(6'h08, "R6 match of zero after restart");
    // R10 irq and set-over-clear
    wr(6'h0C, 32'h07); idle(3);
    chk("R10 irq asserted", 32'(irq_o), 32'(|(m_sts & m_ier)));
    for (int k = 0; k < 8; k++) wr(6'h08, 32'h07);
    rd_chk(6'h08, "R10 set wins over clear");
    wr(6'h0C, 32'h0);
    // R8 force
    wr(6'h00, (32'd3 << 20) | (32'd2 << 23) | (32'd1 << 26));
    wr(6'h00, (32'd3 << 20) | (32'd2 << 23) | (32'd1 << 26) | 32'hE000_0000);
    chk("R8 forced pins", 32'(cmp_o), 32'(m_pin));
    rd_chk(6'h00, "R8 force bits read zero");
    rd_chk(6'h08, "R8 no flag on force");
    wr(6'h00, (32'd3 << 20) | (32'd2 << 23) | (32'd1 << 26) | 32'h8000_0000);
    chk("R8 toggle force", 32'(cmp_o), 32'(m_pin));
    // R9 capture
    wr(6'h00, EN | FR | S1 | (32'd1 << 16) | (32'd3 << 18));
    idle(4); cap_i = 2'b11; idle(3); cap_i = 2'b00; idle(5);
    rd_chk(6'h1C, "R9 rising capture"); rd_chk(6'h20, "R9 both-edge capture");
    wr(6'h00, EN | FR | S1 | (32'd2 << 16));
    idle(2); cap_i = 2'b01; idle(4); rd_chk(6'h1C, "R9 no capture on rise in falling mode");
    cap_i = 2'b00; idle(2); rd_chk(6'h1C, "R9 falling capture"); rd_chk(6'h08, "R9 capture flags");
    // R5 rollover
    wr(6'h08, 32'h3F); wr(6'h0C, 32'h20);
    wr(6'h00, FR | S1); wr(6'h00, EN | ENM | FR | S1);
    idle(1020); rd_chk(6'h08, "R5 before wrap");
    idle(10); rd_chk(6'h08, "R5 rollover flag"); rd_chk(6'h24, "R5 wrapped count");
    chk("R5 rollover seen", 32'(m_sts[5]), 32'd1);
    // R2 soft reset
    wr(6'h10, 32'd9);
    wr(6'h00, EN | FR | S1 | 32'h8000);
    rd_chk(6'h00, "R2 busy bit reads back");
    idle(1);
    rd_chk(6'h00, "R2 ctrl cleared"); rd_chk(6'h24, "R2 count cleared");
    rd_chk(6'h10, "R2 compare restored"); rd_chk(6'h08, "R2 status cleared");
    idle(2);
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_up();
  end
endmodule